// File: doc/BRIEF.md
# Byte-Order Selectable Host Data Buffer

This block is the byte store between a host data register that is two bytes wide and a byte-serial transfer engine. The store is four byte lanes wide. Transmit data and receive data use the same lanes, and each direction has its own occupancy count. The host loads transmit data one word at a time: each word puts two bytes into the store, and a single byte may close a burst. The engine takes transmit bytes one at a time, oldest first. In the other direction, the engine pushes received bytes into the lanes one at a time. A host read then takes up to two of them and returns them as one word.

A big-endian select input sets how the two halves of the host word map onto wire order. When it is set, the upper half of a host word is the byte that goes out first on the wire, or the byte that came in first. When it is clear, the halves swap. The block drives status flags for the status logic next to it: transmit underflow, transmit ready, receive overrun, receive ready, and a sticky flag for a read from an empty buffer.

Only one operation acts in a clock cycle. The host has priority over the engine.

Top module: `bswap_fifo_port`

## Requirements
- R1: After synchronous reset, tx_count and rx_count are 0 and all five flags are 0.
- R2: An accepted word write (host_wr, when tx_count <= 2) moves every held lane up by two positions. It puts the first-wire byte in lane 1 and the other byte in lane 0, and adds 2 to tx_count. The first-wire byte is host_wdata[15:8] when be_mode=1 and host_wdata[7:0] when be_mode=0. A word write while tx_count > 2 changes nothing.
- R3: eng_txd shows lane (tx_count-1), or 0 when tx_count is 0. An eng_pop with data held lowers tx_count by 1. Bytes therefore leave in the order they were written, with each word's first-wire byte leading.
- R4: A byte write (host_wr_byte) is accepted only when host_last=1 and tx_count < 4. It moves the lanes up by one position, puts host_wdata[7:0] in lane 0, and adds 1 to tx_count. Any other byte write changes nothing.
- R5: An eng_pop at tx_count 0 sets flag_xudf and flag_xrdy. An eng_pop that takes tx_count from 1 to 0 sets flag_xrdy. An accepted write of either kind clears both flags.
- R6: An eng_push stores eng_rxd in lane rx_count, adds 1 to rx_count and sets flag_rrdy. At rx_count 4 the byte is dropped, rx_count stays at 4, and flag_rovr is set.
- R7: With rx_count >= 2, host_rdata is {lane0, lane1} when be_mode=1 and {lane1, lane0} when be_mode=0. A host_rd then removes both bytes, moves the remaining lanes down by two positions and lowers rx_count by 2.
- R8: With rx_count 1, host_rdata is {8'h00, lane0}, and a host_rd removes that one byte.
- R9: A host_rd at rx_count 0 sets flag_sbd, leaves rx_count unchanged, and host_rdata reads 0. flag_sbd stays set until reset. A read that returns data clears flag_rovr. A read that empties the buffer also clears flag_rrdy.
- R10: Only one request acts per cycle, taken in this priority order: word write, byte write, read, push, pop. Lower-ranked requests in the same cycle are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| be_mode | input | 1 | 1: upper half of the host word is the first byte on the wire |
| host_wr | input | 1 | Word write strobe |
| host_wr_byte | input | 1 | Single-byte write strobe |
| host_last | input | 1 | Marks the current host write as the last of a burst |
| host_wdata | input | 16 | Host write word |
| host_rd | input | 1 | Read strobe; removes the bytes shown on host_rdata |
| host_rdata | output | 16 | Received word assembled from lanes 0 and 1 |
| eng_pop | input | 1 | Engine takes one transmit byte |
| eng_txd | output | 8 | Next transmit byte |
| eng_push | input | 1 | Engine delivers one received byte |
| eng_rxd | input | 8 | Received byte |
| tx_count | output | 3 | Transmit bytes held |
| rx_count | output | 3 | Receive bytes held |
| flag_xudf | output | 1 | Transmit underflow |
| flag_xrdy | output | 1 | Transmit side wants data |
| flag_rovr | output | 1 | Receive overrun |
| flag_rrdy | output | 1 | Receive data present |
| flag_sbd | output | 1 | Sticky: host read found no data |

## Verification
The bench runs every path in both byte orders over several data words. It fills the transmit side to capacity and checks that a third word is refused. A design that swapped halves wrongly, or that let a later word overtake an earlier one, would send bytes out of order. It also pushes a fifth receive byte into a full buffer. A design that overwrote a lane there, or that left the overrun flag standing after a good read, would return the wrong word or the wrong flags. It also checks the one-byte read, the read from an empty buffer, and non-final byte writes. A design that consumed two bytes on the one-byte read, failed to hold the sticky flag, or accepted a non-final byte write would show the wrong count or data. Finally, requests are made in the same cycle to test the priority rule.

// File: rtl/bfp_pkg.sv
package bfp_pkg;

    typedef enum logic [2:0] {
        OP_IDLE,
        OP_WR_WORD,
        OP_WR_BYTE,
        OP_DROP,
        OP_READ,
        OP_PUSH,
        OP_POP
    } bfp_op_e;

    typedef struct packed {
        logic xudf;
        logic xrdy;
        logic rovr;
        logic rrdy;
        logic sbd;
    } bfp_flags_t;

    // Fixed priority: word write, byte write, read, push, pop.
    function automatic bfp_op_e pick_op(input logic wr, input logic wr_byte,
                                        input logic last, input logic rd,
                                        input logic push, input logic pop);
        bfp_op_e op;
        if (wr)           op = OP_WR_WORD;
        else if (wr_byte) op = last ? OP_WR_BYTE : OP_DROP;
        else if (rd)      op = OP_READ;
        else if (push)    op = OP_PUSH;
        else if (pop)     op = OP_POP;
        else              op = OP_IDLE;
        return op;
    endfunction

endpackage

// File: rtl/bfp_lane_order.sv
module bfp_lane_order #(
    parameter int BYTE_W = 8
) (
    input  logic                  be_mode,
    input  logic [2*BYTE_W-1:0]   host_word,
    input  logic [BYTE_W-1:0]     rd_lane0,
    input  logic [BYTE_W-1:0]     rd_lane1,
    output logic [BYTE_W-1:0]     wr_lane1,
    output logic [BYTE_W-1:0]     wr_lane0,
    output logic [2*BYTE_W-1:0]   rd_word
);
    logic [BYTE_W-1:0] hi_half;
    logic [BYTE_W-1:0] lo_half;

    assign hi_half = host_word[2*BYTE_W-1:BYTE_W];
    assign lo_half = host_word[BYTE_W-1:0];

    // Lane 1 leaves first on transmit; lane 0 arrived first on receive.
    assign wr_lane1 = be_mode ? hi_half : lo_half;
    assign wr_lane0 = be_mode ? lo_half : hi_half;
    assign rd_word  = be_mode ? {rd_lane0, rd_lane1} : {rd_lane1, rd_lane0};
endmodule

// File: rtl/bfp_store.sv
module bfp_store
    import bfp_pkg::*;
#(
    parameter  int LANES  = 4,
    parameter  int BYTE_W = 8,
    localparam int CW     = $clog2(LANES + 1),
    localparam int SW     = LANES * BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  bfp_op_e           op,
    input  logic [BYTE_W-1:0] wr_lane1,
    input  logic [BYTE_W-1:0] wr_lane0,
    input  logic [BYTE_W-1:0] byte_in,
    input  logic [BYTE_W-1:0] rx_byte,
    output logic [SW-1:0]     lanes,
    output logic [CW-1:0]     tx_cnt,
    output logic [CW-1:0]     rx_cnt,
    output logic              wr_word_ok,
    output logic              wr_byte_ok
);
    logic [SW-1:0] store_q, store_d;
    logic [CW-1:0] tx_q, tx_d, rx_q, rx_d;

    assign wr_word_ok = (tx_q <= CW'(LANES - 2));
    assign wr_byte_ok = (tx_q < CW'(LANES));

    always_comb begin
        store_d = store_q;
        tx_d    = tx_q;
        rx_d    = rx_q;
        unique case (op)
            OP_WR_WORD: if (wr_word_ok) begin
                store_d = (store_q << (2 * BYTE_W)) | SW'({wr_lane1, wr_lane0});
                tx_d    = tx_q + CW'(2);
            end
            OP_WR_BYTE: if (wr_byte_ok) begin
                store_d = (store_q << BYTE_W) | SW'(byte_in);
                tx_d    = tx_q + CW'(1);
            end
            OP_READ: begin
                if (rx_q >= CW'(2)) begin
                    store_d = store_q >> (2 * BYTE_W);
                    rx_d    = rx_q - CW'(2);
                end else if (rx_q == CW'(1)) begin
                    store_d = store_q >> BYTE_W;
                    rx_d    = '0;
                end
            end
            OP_PUSH: if (rx_q < CW'(LANES)) begin
                for (int i = 0; i < LANES; i++) begin
                    if (CW'(i) == rx_q) store_d[i*BYTE_W +: BYTE_W] = rx_byte;
                end
                rx_d = rx_q + CW'(1);
            end
            OP_POP: if (tx_q != '0) tx_d = tx_q - CW'(1);
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            store_q <= '0;
            tx_q    <= '0;
            rx_q    <= '0;
        end else begin
            store_q <= store_d;
            tx_q    <= tx_d;
            rx_q    <= rx_d;
        end
    end

    assign lanes  = store_q;
    assign tx_cnt = tx_q;
    assign rx_cnt = rx_q;
endmodule

// File: rtl/bfp_flags.sv
module bfp_flags
    import bfp_pkg::*;
#(
    parameter  int LANES = 4,
    localparam int CW    = $clog2(LANES + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  bfp_op_e       op,
    input  logic [CW-1:0] tx_cnt,
    input  logic [CW-1:0] rx_cnt,
    input  logic          wr_word_ok,
    input  logic          wr_byte_ok,
    output bfp_flags_t    flags
);
    bfp_flags_t flags_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
        end else begin
            unique case (op)
                OP_WR_WORD, OP_WR_BYTE: begin
                    if ((op == OP_WR_WORD && wr_word_ok) ||
                        (op == OP_WR_BYTE && wr_byte_ok)) begin
                        flags_q.xudf <= 1'b0;
                        flags_q.xrdy <= 1'b0;
                    end
                end
                OP_POP: begin
                    if (tx_cnt == '0) begin
                        flags_q.xudf <= 1'b1;
                        flags_q.xrdy <= 1'b1;
                    end else if (tx_cnt == CW'(1)) begin
                        flags_q.xrdy <= 1'b1;
                    end
                end
                OP_PUSH: begin
                    flags_q.rrdy <= 1'b1;
                    if (rx_cnt == CW'(LANES)) flags_q.rovr <= 1'b1;
                end
                OP_READ: begin
                    if (rx_cnt == '0) begin
                        flags_q.sbd <= 1'b1;
                    end else begin
                        flags_q.rovr <= 1'b0;
                        if (rx_cnt <= CW'(2)) flags_q.rrdy <= 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end

    assign flags = flags_q;
endmodule

// File: rtl/bswap_fifo_port.sv
module bswap_fifo_port
    import bfp_pkg::*;
#(
    parameter  int LANES  = 4,
    parameter  int BYTE_W = 8,
    localparam int CW     = $clog2(LANES + 1),
    localparam int HW     = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              be_mode,
    input  logic              host_wr,
    input  logic              host_wr_byte,
    input  logic              host_last,
    input  logic [HW-1:0]     host_wdata,
    input  logic              host_rd,
    output logic [HW-1:0]     host_rdata,
    input  logic              eng_pop,
    output logic [BYTE_W-1:0] eng_txd,
    input  logic              eng_push,
    input  logic [BYTE_W-1:0] eng_rxd,
    output logic [CW-1:0]     tx_count,
    output logic [CW-1:0]     rx_count,
    output logic              flag_xudf,
    output logic              flag_xrdy,
    output logic              flag_rovr,
    output logic              flag_rrdy,
    output logic              flag_sbd
);
    localparam int SW = LANES * BYTE_W;

    bfp_op_e           op;
    logic [SW-1:0]     lanes;
    logic [BYTE_W-1:0] wr_lane1, wr_lane0;
    logic [HW-1:0]     pair_word;
    logic              wr_word_ok, wr_byte_ok;
    bfp_flags_t        flags;

    assign op = pick_op(host_wr, host_wr_byte, host_last, host_rd, eng_push, eng_pop);

    bfp_lane_order #(.BYTE_W(BYTE_W)) u_order (
        .be_mode  (be_mode),
        .host_word(host_wdata),
        .rd_lane0 (lanes[BYTE_W-1:0]),
        .rd_lane1 (lanes[2*BYTE_W-1:BYTE_W]),
        .wr_lane1 (wr_lane1),
        .wr_lane0 (wr_lane0),
        .rd_word  (pair_word)
    );

    bfp_store #(.LANES(LANES), .BYTE_W(BYTE_W)) u_store (
        .clk       (clk),
        .rst       (rst),
        .op        (op),
        .wr_lane1  (wr_lane1),
        .wr_lane0  (wr_lane0),
        .byte_in   (host_wdata[BYTE_W-1:0]),
        .rx_byte   (eng_rxd),
        .lanes     (lanes),
        .tx_cnt    (tx_count),
        .rx_cnt    (rx_count),
        .wr_word_ok(wr_word_ok),
        .wr_byte_ok(wr_byte_ok)
    );

    bfp_flags #(.LANES(LANES)) u_flags (
        .clk       (clk),
        .rst       (rst),
        .op        (op),
        .tx_cnt    (tx_count),
        .rx_cnt    (rx_count),
        .wr_word_ok(wr_word_ok),
        .wr_byte_ok(wr_byte_ok),
        .flags     (flags)
    );

    always_comb begin
        if (rx_count >= CW'(2))      host_rdata = pair_word;
        else if (rx_count == CW'(1)) host_rdata = HW'(lanes[BYTE_W-1:0]);
        else                         host_rdata = '0;
    end

    always_comb begin
        eng_txd = '0;
        for (int i = 0; i < LANES; i++) begin
            if (CW'(i + 1) == tx_count) eng_txd = lanes[i*BYTE_W +: BYTE_W];
        end
    end

    assign flag_xudf = flags.xudf;
    assign flag_xrdy = flags.xrdy;
    assign flag_rovr = flags.rovr;
    assign flag_rrdy = flags.rrdy;
    assign flag_sbd  = flags.sbd;
endmodule

// File: rtl/bfp_checker.sv
module bfp_checker #(
    parameter  int LANES = 4,
    localparam int CW    = $clog2(LANES + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          host_wr,
    input logic          host_wr_byte,
    input logic          host_rd,
    input logic          eng_push,
    input logic          eng_pop,
    input logic [CW-1:0] tx_count,
    input logic [CW-1:0] rx_count,
    input logic          flag_xudf,
    input logic          flag_xrdy,
    input logic          flag_rovr,
    input logic          flag_sbd
);
    logic host_any;
    assign host_any = host_wr | host_wr_byte | host_rd;

    assert_tx_bound_R2: assert property (@(posedge clk) disable iff (rst)
        tx_count <= CW'(LANES));

    assert_word_write_R2: assert property (@(posedge clk) disable iff (rst)
        (host_wr && tx_count <= CW'(LANES - 2)) |=> tx_count == $past(tx_count) + CW'(2));

    assert_pop_empty_R5: assert property (@(posedge clk) disable iff (rst)
        (eng_pop && !host_any && !eng_push && tx_count == '0) |=> (flag_xudf && flag_xrdy));

    assert_push_full_R6: assert property (@(posedge clk) disable iff (rst)
        (eng_push && !host_any && rx_count == CW'(LANES)) |=> (flag_rovr && rx_count == CW'(LANES)));

    assert_empty_read_R9: assert property (@(posedge clk) disable iff (rst)
        (host_rd && !host_wr && !host_wr_byte && rx_count == '0) |=> (flag_sbd && rx_count == '0));

    assert_sbd_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        flag_sbd |=> flag_sbd);

    assert_write_wins_R10: assert property (@(posedge clk) disable iff (rst)
        host_wr |=> rx_count == $past(rx_count));
endmodule

bind bswap_fifo_port bfp_checker #(.LANES(LANES)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .host_wr     (host_wr),
    .host_wr_byte(host_wr_byte),
    .host_rd     (host_rd),
    .eng_push    (eng_push),
    .eng_pop     (eng_pop),
    .tx_count    (tx_count),
    .rx_count    (rx_count),
    .flag_xudf   (flag_xudf),
    .flag_xrdy   (flag_xrdy),
    .flag_rovr   (flag_rovr),
    .flag_sbd    (flag_sbd)
);

// File: tb/bswap_fifo_port_tb.sv
module bswap_fifo_port_tb;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst;
    logic be_mode, host_wr, host_wr_byte, host_last, host_rd, eng_pop, eng_push;
    logic [15:0] host_wdata, host_rdata;
    logic [7:0]  eng_txd, eng_rxd;
    logic [2:0]  tx_count, rx_count;
    logic flag_xudf, flag_xrdy, flag_rovr, flag_rrdy, flag_sbd;

    int compared = 0;
    int mismatched = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bswap_fifo_port u_dut (
        .clk(clk), .rst(rst), .be_mode(be_mode), .host_wr(host_wr),
        .host_wr_byte(host_wr_byte), .host_last(host_last), .host_wdata(host_wdata),
        .host_rd(host_rd), .host_rdata(host_rdata), .eng_pop(eng_pop), .eng_txd(eng_txd),
        .eng_push(eng_push), .eng_rxd(eng_rxd), .tx_count(tx_count), .rx_count(rx_count),
        .flag_xudf(flag_xudf), .flag_xrdy(flag_xrdy), .flag_rovr(flag_rovr),
        .flag_rrdy(flag_rrdy), .flag_sbd(flag_sbd)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        compared++;
        if (got !== exp) begin
            mismatched++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic clear_inputs();
        host_wr = 0; host_wr_byte = 0; host_last = 0; host_rd = 0;
        eng_pop = 0; eng_push = 0; host_wdata = '0; eng_rxd = '0;
    endtask

    // Drive at the falling edge, let one rising edge act, settle, release.
    task automatic step(input logic wr, input logic wb, input logic last, input logic rd,
                        input logic push, input logic pop, input logic [15:0] wd,
                        input logic [7:0] rxd);
        @(negedge clk);
        host_wr = wr; host_wr_byte = wb; host_last = last; host_rd = rd;
        eng_push = push; eng_pop = pop; host_wdata = wd; eng_rxd = rxd;
        @(posedge clk);
        #1;
        clear_inputs();
    endtask

    function automatic logic [7:0] first_b(input logic [15:0] w, input logic be);
        return be ? w[15:8] : w[7:0];
    endfunction
    function automatic logic [7:0] second_b(input logic [15:0] w, input logic be);
        return be ? w[7:0] : w[15:8];
    endfunction

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        clear_inputs();
        be_mode = 1'b1;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        check("R1 tx_count", tx_count, 0);
        check("R1 rx_count", rx_count, 0);
        check("R1 flags", {flag_xudf, flag_xrdy, flag_rovr, flag_rrdy, flag_sbd}, 0);

        // Transmit path sweep
        for (int be = 0; be < 2; be++) begin
            be_mode = be[0];
            for (int k = 0; k < 8; k++) begin
                logic [15:0] w1, w2;
                logic [7:0] seq [4];
                w1 = 16'(k * 16'h1357 + 16'h2468 + be * 16'h0101);
                w2 = ~w1 ^ 16'(k * 16'h0F1E);
                seq[0] = first_b(w1, be[0]); seq[1] = second_b(w1, be[0]);
                seq[2] = first_b(w2, be[0]); seq[3] = second_b(w2, be[0]);
                step(1, 0, 0, 0, 0, 0, w1, 0);
                check("R5 write clears xudf", flag_xudf, 0);
                check("R5 write clears xrdy", flag_xrdy, 0);
                check("R2 count after one word", tx_count, 2);
                step(1, 0, 0, 0, 0, 0, w2, 0);
                check("R2 count after two words", tx_count, 4);
                step(1, 0, 0, 0, 0, 0, 16'hDEAD, 0);
                check("R2 write refused when full", tx_count, 4);
                for (int j = 0; j < 4; j++) begin
                    check("R3 transmit byte order", eng_txd, seq[j]);
                    step(0, 0, 0, 0, 0, 1, 0, 0);
                    check("R3 pop count", tx_count, 3 - j);
                end
                check("R5 xrdy after last pop", flag_xrdy, 1);
                check("R5 no xudf yet", flag_xudf, 0);
                check("R3 empty txd", eng_txd, 0);
                step(0, 0, 0, 0, 0, 1, 0, 0);
                check("R5 underflow flag", flag_xudf, 1);
                check("R5 underflow count", tx_count, 0);
            end
        end

        // Byte writes
        step(0, 1, 0, 0, 0, 0, 16'hAB5C, 0);
        check("R4 non-final byte write ignored", tx_count, 0);
        check("R4 ignored write keeps xudf", flag_xudf, 1);
        step(0, 1, 1, 0, 0, 0, 16'hAB5C, 0);
        check("R4 final byte write count", tx_count, 1);
        check("R4 final byte value", eng_txd, 8'h5C);
        step(0, 0, 0, 0, 0, 1, 0, 0);
        check("R4 byte popped", tx_count, 0);

        // Receive path sweep
        for (int be = 0; be < 2; be++) begin
            be_mode = be[0];
            for (int k = 0; k < 4; k++) begin
                logic [7:0] b [4];
                for (int i = 0; i < 4; i++) b[i] = 8'(8'h30 + i * 17 + be * 5 + k * 3);
                for (int i = 0; i < 4; i++) begin
                    step(0, 0, 0, 0, 1, 0, 0, b[i]);
                    check("R6 push count", rx_count, i + 1);
                    check("R6 rrdy", flag_rrdy, 1);
                end
                step(0, 0, 0, 0, 1, 0, 0, 8'hEE);
                check("R6 overrun flag", flag_rovr, 1);
                check("R6 overrun count", rx_count, 4);
                check("R7 first pair", host_rdata, be ? {b[0], b[1]} : {b[1], b[0]});
                step(0, 0, 0, 1, 0, 0, 0, 0);
                check("R9 good read clears rovr", flag_rovr, 0);
                check("R7 count after read", rx_count, 2);
                check("R7 second pair", host_rdata, be ? {b[2], b[3]} : {b[3], b[2]});
                step(0, 0, 0, 1, 0, 0, 0, 0);
                check("R9 emptying read clears rrdy", flag_rrdy, 0);
                check("R7 empty after reads", rx_count, 0);
                check("R9 empty rdata", host_rdata, 0);
                step(0, 0, 0, 1, 0, 0, 0, 0);
                check("R9 sbd set", flag_sbd, 1);
                check("R9 empty read count", rx_count, 0);
                for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 1, 0, 0, b[i]);
                step(0, 0, 0, 1, 0, 0, 0, 0);
                check("R8 single byte in low lane", host_rdata, {8'h00, b[2]});
                check("R8 rrdy held", flag_rrdy, 1);
                step(0, 0, 0, 1, 0, 0, 0, 0);
                check("R8 single byte consumed", rx_count, 0);
                check("R9 sbd sticky", flag_sbd, 1);
            end
        end

        // Priority
        be_mode = 1'b1;
        step(1, 0, 0, 0, 1, 0, 16'h1234, 8'h77);
        check("R10 write beats push (rx)", rx_count, 0);
        check("R10 write applied", tx_count, 2);
        step(0, 0, 0, 1, 0, 1, 0, 0);
        check("R10 read beats pop", tx_count, 2);
        step(0, 0, 0, 0, 1, 1, 0, 8'h42);
        check("R10 push beats pop (tx)", tx_count, 2);
        check("R10 push applied", rx_count, 1);
        check("R10 pushed byte", host_rdata, 16'h0042);
        check("R3 txd after priority", eng_txd, 8'h12);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule